// File: doc/BRIEF.md
# Grouped Priority Preemption Resolver

This block picks the next interrupt line to service from a vector of lines that are already enabled and pending. Each line has a 4-bit priority value, smaller meaning more urgent. A global grouping setting splits that value into two parts. The upper bits form a preemption level and the lower bits a sub-priority.

The block combines the stored priorities with the age of each pending request and with a stack of the preemption levels now running. From these it raises a take request that names the winning line. A handler may nest over the running one only through a strictly better preemption level. The sub-priority and the arrival order only decide which waiting line goes first.

The processor side accepts a take with `takeAck`, which pushes the winner's preemption level. It reports the end of a handler with `doneStrobe`, which pops that level. Software programs the priorities and the grouping through a word-wide register port. The enable and pending bookkeeping lives outside the block.

Top module: `irq_preempt_resolver`

## Requirements
- R1: After reset, `takeReq` is low, every register word reads 0 and no handler counts as running.
- R2: Priority words sit at addresses 0 to 14. Line n lives in word n/4, byte n%4, and only bits [7:4] of that byte are stored. Bits [3:0] of every byte read as 0 whatever was written.
- R3: The grouping field sits at address 15, bits [2:0], and reads back as written. With group g, the top g bits of a line's 4-bit value form its preemption level. Values 5, 6 and 7 act exactly as 4.
- R4: When no handler runs and at least one line is pending, `takeReq` is high and `takeLine` is the pending line with the smallest 4-bit value. `takeReq` is low whenever no line is pending.
- R5: While a handler runs, a pending line is offered only when its preemption level is strictly smaller than the level on top of the running stack.
- R6: A pending line whose preemption level equals the running one is not offered, even with a better sub-priority. It is offered once the running handler completes.
- R7: Among pending lines with equal 4-bit values, the one that became pending in an earlier cycle wins. This holds while the wait stays below 255 cycles.
- R8: Among equal-valued lines that became pending in the same cycle, the lowest line number wins.
- R9: A cycle with `takeReq` and `takeAck` high pushes the winner's preemption level. `doneStrobe` pops one level and is ignored when the stack is empty. When a take and a completion happen in the same cycle, the top level is replaced.
- R10: With group 0, every line has the same preemption level, so no line ever nests over a running handler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Register word address for both read and write |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for `regAddr`, combinational |
| pendVec | input | 60 | Enabled-and-pending lines, one bit per line |
| takeAck | input | 1 | Processor accepts the offered line this cycle |
| doneStrobe | input | 1 | The running handler completes this cycle |
| takeReq | output | 1 | A line may be taken now |
| takeLine | output | 6 | Number of the offered line, valid with `takeReq` |

## Verification
A stored priority that is wrong shows up in the same cycle at `takeLine`, or on the next read of its word. A stale age counter reorders equal-valued lines as soon as two of them wait together. A running stack that is wrong by one level does not show at once. It shows later: a blocked line appears too early, or a nesting line is held back. So the bench keeps a behavioural stack and pending history, and compares `takeReq`, `takeLine` and the read data on every clock through nest, complete and replace sequences.

// File: rtl/irqpr_pkg.sv
package irqpr_pkg;
  // Strobes the control hands to the datapath each cycle.
  typedef struct packed {
    logic wrPrio;   // write a priority word
    logic wrGroup;  // write the grouping field
    logic push;     // a take happened: push the winner's level
    logic pop;      // a handler completed: pop one level
  } irqStrobes_t;
endpackage

// File: rtl/irqpr_datapath.sv
module irqpr_datapath
  import irqpr_pkg::*;
#(
  parameter int NUM_LINES = 60,
  parameter int PRIO_BITS = 4,
  parameter int AGE_BITS  = 8,
  localparam int WORDS    = (NUM_LINES + 3) / 4,
  localparam int ADDR_W   = $clog2(WORDS + 1),
  localparam int LINE_W   = $clog2(NUM_LINES),
  localparam int GRP_W    = $clog2(PRIO_BITS + 1),
  localparam int DEPTH    = 1 << PRIO_BITS,
  localparam int PTR_W    = $clog2(DEPTH),
  localparam int SP_W     = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  irqStrobes_t          strb,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [31:0]          regWrData,
  output logic [31:0]          regRdData,
  input  logic [NUM_LINES-1:0] pendVec,
  output logic                 winValid,
  output logic [LINE_W-1:0]    winLine,
  output logic [PRIO_BITS-1:0] winPreempt,
  output logic [PRIO_BITS-1:0] stackTop,
  output logic [SP_W-1:0]      stackDepth
);
  localparam logic [ADDR_W-1:0] GRP_ADDR = ADDR_W'(WORDS);
  localparam int LO = 8 - PRIO_BITS;  // lowest stored bit inside a byte

  logic [PRIO_BITS-1:0] prioMem [NUM_LINES];
  logic [AGE_BITS-1:0]  ageVec  [NUM_LINES];
  logic [GRP_W-1:0]     grpReg;
  logic [PRIO_BITS-1:0] lvlStack [DEPTH];
  logic [SP_W-1:0]      sp;
  logic [SP_W-1:0]      spm1;
  logic [PRIO_BITS-1:0] winPrio;
  logic [GRP_W-1:0]     grpEff;
  logic [GRP_W-1:0]     shAmt;
  logic                 unusedWrBits;

  assign unusedWrBits = ^regWrData;

  // Priority storage: only the top PRIO_BITS of each byte are kept.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_LINES; i++) prioMem[i] <= '0;
    end else if (strb.wrPrio) begin
      for (int i = 0; i < NUM_LINES; i++) begin
        if (int'(regAddr) == i / 4)
          prioMem[i] <= regWrData[8*(i%4)+LO +: PRIO_BITS];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              grpReg <= '0;
    else if (strb.wrGroup)  grpReg <= regWrData[GRP_W-1:0];
  end

  // One saturating age counter per line; it restarts whenever the line drops.
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_age
    logic [AGE_BITS-1:0] cnt;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               cnt <= '0;
      else if (!pendVec[i])    cnt <= '0;
      else if (cnt != '1)      cnt <= cnt + 1'b1;
    end
    assign ageVec[i] = cnt;
  end

  // Read mux: priority words with cleared low bits, or the grouping field.
  always_comb begin
    regRdData = '0;
    if (regAddr == GRP_ADDR) begin
      regRdData[GRP_W-1:0] = grpReg;
    end else if (int'(regAddr) < WORDS) begin
      for (int b = 0; b < 4; b++) begin
        if (int'(regAddr) * 4 + b < NUM_LINES)
          regRdData[8*b+LO +: PRIO_BITS] = prioMem[int'(regAddr) * 4 + b];
      end
    end
  end

  // Arbitration: smallest value, then oldest, then lowest index (strict compare).
  always_comb begin
    logic [AGE_BITS-1:0] bestAge;
    winValid = 1'b0;
    winLine  = '0;
    winPrio  = '1;
    bestAge  = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (pendVec[i] &&
          (!winValid || prioMem[i] < winPrio ||
           (prioMem[i] == winPrio && ageVec[i] > bestAge))) begin
        winValid = 1'b1;
        winLine  = LINE_W'(i);
        winPrio  = prioMem[i];
        bestAge  = ageVec[i];
      end
    end
  end

  // Preemption level of the winner under the current grouping.
  assign grpEff     = (grpReg > GRP_W'(PRIO_BITS)) ? GRP_W'(PRIO_BITS) : grpReg;
  assign shAmt      = GRP_W'(PRIO_BITS) - grpEff;
  assign winPreempt = winPrio >> shAmt;

  // Stack of running preemption levels.
  assign spm1       = sp - 1'b1;
  assign stackDepth = sp;
  assign stackTop   = (sp == '0) ? '0 : lvlStack[spm1[PTR_W-1:0]];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sp <= '0;
      for (int d = 0; d < DEPTH; d++) lvlStack[d] <= '0;
    end else if (strb.push && strb.pop) begin
      lvlStack[spm1[PTR_W-1:0]] <= winPreempt;
    end else if (strb.push && sp < SP_W'(DEPTH)) begin
      lvlStack[sp[PTR_W-1:0]] <= winPreempt;
      sp <= sp + 1'b1;
    end else if (strb.pop) begin
      sp <= spm1;
    end
  end
endmodule

// File: rtl/irqpr_control.sv
module irqpr_control
  import irqpr_pkg::*;
#(
  parameter int NUM_LINES = 60,
  parameter int PRIO_BITS = 4,
  localparam int WORDS    = (NUM_LINES + 3) / 4,
  localparam int ADDR_W   = $clog2(WORDS + 1),
  localparam int SP_W     = $clog2((1 << PRIO_BITS) + 1)
) (
  input  logic                 regWrEn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic                 takeAck,
  input  logic                 doneStrobe,
  input  logic                 winValid,
  input  logic [PRIO_BITS-1:0] winPreempt,
  input  logic [PRIO_BITS-1:0] stackTop,
  input  logic [SP_W-1:0]      stackDepth,
  output logic                 takeReq,
  output irqStrobes_t          strb
);
  localparam logic [ADDR_W-1:0] GRP_ADDR = ADDR_W'(WORDS);

  logic running;
  logic nestOk;

  assign running = (stackDepth != '0);
  // Only a strictly better preemption level may nest over the running one.
  assign nestOk  = !running || (winPreempt < stackTop);
  assign takeReq = winValid && nestOk;

  always_comb begin
    strb         = '0;
    strb.wrPrio  = regWrEn && (regAddr < GRP_ADDR);
    strb.wrGroup = regWrEn && (regAddr == GRP_ADDR);
    strb.push    = takeReq && takeAck;
    strb.pop     = doneStrobe && running;
  end
endmodule

// File: rtl/irq_preempt_resolver.sv
module irq_preempt_resolver
  import irqpr_pkg::*;
#(
  parameter int NUM_LINES = 60,
  parameter int PRIO_BITS = 4,
  parameter int AGE_BITS  = 8,
  localparam int WORDS    = (NUM_LINES + 3) / 4,
  localparam int ADDR_W   = $clog2(WORDS + 1),
  localparam int LINE_W   = $clog2(NUM_LINES),
  localparam int SP_W     = $clog2((1 << PRIO_BITS) + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [31:0]          regWrData,
  output logic [31:0]          regRdData,
  input  logic [NUM_LINES-1:0] pendVec,
  input  logic                 takeAck,
  input  logic                 doneStrobe,
  output logic                 takeReq,
  output logic [LINE_W-1:0]    takeLine
);
  irqStrobes_t          strb;
  logic                 winValid;
  logic [PRIO_BITS-1:0] winPreempt;
  logic [PRIO_BITS-1:0] stackTop;
  logic [SP_W-1:0]      stackDepth;

  irqpr_datapath #(
    .NUM_LINES(NUM_LINES), .PRIO_BITS(PRIO_BITS), .AGE_BITS(AGE_BITS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .pendVec(pendVec),
    .winValid(winValid), .winLine(takeLine), .winPreempt(winPreempt),
    .stackTop(stackTop), .stackDepth(stackDepth)
  );

  irqpr_control #(
    .NUM_LINES(NUM_LINES), .PRIO_BITS(PRIO_BITS)
  ) u_ctl (
    .regWrEn(regWrEn), .regAddr(regAddr), .takeAck(takeAck),
    .doneStrobe(doneStrobe), .winValid(winValid), .winPreempt(winPreempt),
    .stackTop(stackTop), .stackDepth(stackDepth), .takeReq(takeReq),
    .strb(strb)
  );
endmodule

// File: rtl/irqpr_checker.sv
module irqpr_checker #(
  parameter int NUM_LINES = 60,
  parameter int PRIO_BITS = 4,
  localparam int WORDS    = (NUM_LINES + 3) / 4,
  localparam int ADDR_W   = $clog2(WORDS + 1),
  localparam int LINE_W   = $clog2(NUM_LINES),
  localparam int DEPTH    = 1 << PRIO_BITS,
  localparam int SP_W     = $clog2(DEPTH + 1)
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [ADDR_W-1:0]    regAddr,
  input logic [31:0]          regRdData,
  input logic [NUM_LINES-1:0] pendVec,
  input logic                 takeAck,
  input logic                 doneStrobe,
  input logic                 takeReq,
  input logic [LINE_W-1:0]    takeLine,
  input logic [PRIO_BITS-1:0] stackTop,
  input logic [SP_W-1:0]      stackDepth
);
  logic [31:0] lowMask;
  always_comb begin
    lowMask = '0;
    for (int b = 0; b < 4; b++) lowMask[8*b +: 8] = 8'((1 << (8 - PRIO_BITS)) - 1);
  end

  assert_low_bits_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    (int'(regAddr) < WORDS) |-> ((regRdData & lowMask) == 32'h0));

  assert_offer_is_pending_R4: assert property (@(posedge clk) disable iff (!rstN)
    takeReq |-> pendVec[takeLine]);

  assert_idle_no_offer_R4: assert property (@(posedge clk) disable iff (!rstN)
    (pendVec == '0) |-> !takeReq);

  assert_nest_deeper_R5: assert property (@(posedge clk) disable iff (!rstN)
    (takeReq && takeAck && !doneStrobe && stackDepth != '0) |=> (stackTop < $past(stackTop)));

  assert_push_grows_R9: assert property (@(posedge clk) disable iff (!rstN)
    (takeReq && takeAck && !doneStrobe) |=> (stackDepth == $past(stackDepth) + 1'b1));

  assert_pop_shrinks_R9: assert property (@(posedge clk) disable iff (!rstN)
    (doneStrobe && !takeAck && stackDepth != '0) |=> (stackDepth == $past(stackDepth) - 1'b1));

  assert_depth_bound_R9: assert property (@(posedge clk) disable iff (!rstN)
    stackDepth <= SP_W'(DEPTH));
endmodule

bind irq_preempt_resolver irqpr_checker #(
  .NUM_LINES(NUM_LINES), .PRIO_BITS(PRIO_BITS)
) u_chk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regRdData(regRdData),
  .pendVec(pendVec), .takeAck(takeAck), .doneStrobe(doneStrobe),
  .takeReq(takeReq), .takeLine(takeLine), .stackTop(stackTop),
  .stackDepth(stackDepth)
);

// File: tb/sim_irq_preempt_resolver.sv
`timescale 1ns/1ps
module sim_irq_preempt_resolver;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [59:0] pendVec = '0;
  logic        takeAck = 1'b0;
  logic        doneStrobe = 1'b0;
  logic        takeReq;
  logic [5:0]  takeLine;

  irq_preempt_resolver u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .pendVec(pendVec),
    .takeAck(takeAck), .doneStrobe(doneStrobe), .takeReq(takeReq),
    .takeLine(takeLine)
  );

  always #2 clk = ~clk;  // 250 MHz

  // Behavioural model state
  int prio [60];
  int grp;
  int stk [$];
  int stamp [60];
  bit seen [60];
  int cyc;
  int checks = 0;
  int fails = 0;
  bit finished = 0;

  function automatic int preOf(int p);
    int g;
    g = (grp > 4) ? 4 : grp;
    return p >> (4 - g);
  endfunction

  function automatic int modelRead(int a);
    int w;
    w = 0;
    if (a == 15) w = grp;
    else if (a < 15)
      for (int b = 0; b < 4; b++) w = w | ((prio[a*4+b] & 15) << (8*b + 4));
    return w;
  endfunction

  task automatic calcExp(output bit req, output int line);
    int best, bs, es;
    best = -1; bs = 0;
    for (int i = 0; i < 60; i++) begin
      if (pendVec[i]) begin
        es = seen[i] ? stamp[i] : cyc;
        if (best < 0 || prio[i] < prio[best] || (prio[i] == prio[best] && es < bs)) begin
          best = i; bs = es;
        end
      end
    end
    line = best;
    req  = (best >= 0) && (stk.size() == 0 || preOf(prio[best]) < stk[$]);
  endtask

  task automatic chk(string tag, bit ok, longint act, longint exp, string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // One clock: compare before the edge, then advance the model at the edge.
  task automatic tick(string tag);
    bit er; int el; int erd; int pushLvl; bit doPush; bit doPop;
    #1;
    calcExp(er, el);
    erd = modelRead(int'(regAddr));
    chk(tag, takeReq === er, longint'(takeReq), longint'(er), "takeReq");
    if (er) chk(tag, int'(takeLine) == el, longint'(takeLine), longint'(el), "takeLine");
    chk(tag, regRdData === 32'(erd), longint'(regRdData), longint'(erd), "regRdData");
    @(posedge clk);
    doPush  = er && takeAck;
    doPop   = doneStrobe && stk.size() > 0;
    pushLvl = doPush ? preOf(prio[el]) : 0;
    if (doPop) void'(stk.pop_back());
    if (doPush) stk.push_back(pushLvl);
    if (regWrEn) begin
      if (regAddr == 4'd15) grp = int'(regWrData[2:0]);
      else if (regAddr < 4'd15)
        for (int b = 0; b < 4; b++) prio[regAddr*4+b] = int'(regWrData[8*b+4 +: 4]);
    end
    for (int i = 0; i < 60; i++) begin
      if (pendVec[i] && !seen[i]) stamp[i] = cyc;
      seen[i] = pendVec[i];
    end
    cyc++;
    @(negedge clk);
    if (doPush) pendVec[el] = 1'b0;  // pending bookkeeping clears a taken line
  endtask

  task automatic setPrio(int line, int val);
    logic [31:0] w;
    w = '0;
    for (int b = 0; b < 4; b++)
      w[8*b+4 +: 4] = 4'(((line/4)*4 + b == line) ? val : prio[(line/4)*4 + b]);
    regAddr = 4'(line/4); regWrData = w; regWrEn = 1'b1;
    tick("R2");
    regWrEn = 1'b0;
  endtask

  task automatic setGroup(int v);
    regAddr = 4'd15; regWrData = 32'(v); regWrEn = 1'b1;
    tick("R3");
    regWrEn = 1'b0;
    tick("R3");  // read back
  endtask

  task automatic idle(int n, string tag);
    for (int k = 0; k < n; k++) tick(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=expired expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 60; i++) begin prio[i] = 0; stamp[i] = 0; seen[i] = 0; end
    grp = 0; cyc = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1: reset state through the ports
    regAddr = 4'd0;  tick("R1");
    regAddr = 4'd7;  tick("R1");
    regAddr = 4'd15; tick("R1");

    // R2: layout and dropped low bits
    regAddr = 4'd0; regWrData = 32'hFFFF_FFFF; regWrEn = 1'b1; tick("R2");
    regWrEn = 1'b0; tick("R2");
    regWrData = 32'h1234_5678; regWrEn = 1'b1; tick("R2");
    regWrEn = 1'b0; tick("R2");
    regAddr = 4'd14; regWrData = 32'hA5C3_0F96; regWrEn = 1'b1; tick("R2");
    regWrEn = 1'b0; tick("R2");

    // R3: grouping field readback
    setGroup(7);
    setGroup(2);

    // R4: smallest value wins, no handler running
    setPrio(20, 6); setPrio(33, 2); setPrio(47, 9);
    pendVec[20] = 1; pendVec[47] = 1; idle(2, "R4");
    pendVec[33] = 1; idle(2, "R4");
    pendVec = '0; idle(1, "R4");

    // R7: earlier arrival wins among equal values
    setPrio(40, 5); setPrio(12, 5);
    pendVec[40] = 1; idle(1, "R7");
    pendVec[12] = 1; idle(3, "R7");
    pendVec = '0; idle(1, "R7");
    // R8: same-cycle arrival, lowest number wins
    pendVec[40] = 1; pendVec[12] = 1; idle(3, "R8");
    pendVec = '0; idle(1, "R8");

    // R5 / R6: nesting under group 2 (2 preemption bits)
    setPrio(8, 9); setPrio(9, 8); setPrio(10, 4); setPrio(11, 8); setPrio(13, 10);
    takeAck = 1;
    pendVec[8] = 1; idle(2, "R5");           // taken with nothing running
    pendVec[9] = 1; idle(4, "R6");           // same level, better sub: held
    pendVec[10] = 1; idle(2, "R5");          // better level: nests
    doneStrobe = 1; tick("R9"); doneStrobe = 0;
    idle(2, "R6");                           // back on line 8's level: still held
    doneStrobe = 1; tick("R6"); doneStrobe = 0;
    idle(2, "R6");                           // line 9 now taken
    doneStrobe = 1; tick("R9"); doneStrobe = 0;
    idle(1, "R9");

    // R10: group 0 never nests
    setGroup(0);
    pendVec[8] = 1; idle(2, "R10");
    pendVec[10] = 1; idle(3, "R10");
    doneStrobe = 1; tick("R10"); doneStrobe = 0;
    idle(2, "R10");
    doneStrobe = 1; tick("R10"); doneStrobe = 0;
    idle(1, "R10");

    // R3: group 7 acts as 4 (full value is the level)
    setGroup(7);
    pendVec[8] = 1; idle(2, "R3");
    pendVec[11] = 1; idle(2, "R3");          // 8 < 9 nests
    doneStrobe = 1; tick("R3"); doneStrobe = 0;
    doneStrobe = 1; tick("R3"); doneStrobe = 0;
    idle(1, "R3");

    // R9: completion on empty stack ignored, then take+complete replaces top
    setGroup(4);
    doneStrobe = 1; tick("R9"); doneStrobe = 0;
    pendVec[8] = 1; idle(2, "R9");           // level 9 running
    pendVec[13] = 1; idle(2, "R9");          // 10 held behind 9
    takeAck = 0; pendVec[10] = 1; idle(1, "R9");
    takeAck = 1; doneStrobe = 1; tick("R9"); doneStrobe = 0;  // replace 9 by 4
    idle(2, "R9");                           // 13 held behind 4
    doneStrobe = 1; tick("R9"); doneStrobe = 0;
    idle(2, "R9");                           // stack empty: 13 taken
    doneStrobe = 1; tick("R9"); doneStrobe = 0;
    pendVec = '0; idle(2, "R9");

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule